// File: doc/BRIEF.md
# Packed Symbol Error Corrector

This block repairs a page buffer after a Reed-Solomon decoder has found the bad symbols. The code works on 12-bit symbols stored back to back in a byte stream, so most symbols straddle a nibble boundary. The buffer holds a 2048-byte data area followed by a spare area. The decoder hands over up to four (symbol position, 12-bit error pattern) pairs. For each pair the block works out which one or two bytes the symbol covers, and which bits of the pattern land in each of them. It then patches each byte by a read-modify-write XOR through a synchronous byte RAM port.

A job starts with a one-cycle `start` pulse that carries the pair count and the pairs. The pairs are handled strictly in the order given, one byte update every two clock cycles. At the end, a one-cycle `done` pulse comes with the result: either the count of corrected symbols, or a failure flag and a reason mask. On a failure the good pairs stay applied. Finding the error locations is left to the decoder upstream.

Top module: `symfix_corrector`

## Requirements
- R1: For an odd position p in 1..1374, pattern bits 11:4 are XORed into the byte at address floor(3p/2). Pattern bits 3:0 are XORed into bits 7:4 of the byte after it.
- R2: For an even position p in 2..1374, pattern bits 11:8 are XORed into bits 3:0 of the byte at address 3p/2-1. Pattern bits 7:0 are XORed into the byte at address 3p/2.
- R3: Position 0 holds only 8 data bits. A pattern of 0xFF or less is XORed into byte 0. A larger pattern writes nothing and sets reason bit 1 (first-symbol overflow).
- R4: The data area sits at addresses 0..2047 and spare byte k at address 2048+k. Position 1365 puts its bits 11:4 into byte 2047 and its bits 3:0 into bits 7:4 of spare byte 0. Positions 1366..1374 reach spare bytes 1..13 by the same odd/even rules. No access leaves the 2112-byte buffer.
- R5: A position above 1374 writes nothing and sets reason bit 0 (out of range).
- R6: `pair_count` values above 4 are treated as 4. Pair k sits at `pos_flat[11k+10:11k]` and `pat_flat[12k+11:12k]`. Pairs at and beyond the count are ignored.
- R7: Each byte update reads the byte and writes it back in the next cycle at the same address, with `mem_rdata` valid the cycle after the read. Pairs are applied in slot order, and a later pair sees the bytes written by an earlier one.
- R8: `done` is a one-cycle pulse. It goes high after exactly 1 + Σ(1 + 2·b_k) rising edges following the edge that captured `start`, where b_k is the number of bytes pair k writes (0, 1 or 2).
- R9: At `done`, a job with no bad pair shows `fail`=0, `fail_why`=0 and `corrected` equal to the effective count. A job with any bad pair shows `fail`=1, `corrected`=0 and a reason mask that ORs every bad pair's reason. Good pairs are still applied. These outputs hold until the next job starts.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `fail`, `fail_why`, `corrected` and `mem_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job when idle |
| pair_count | input | 3 | Number of valid pairs |
| pos_flat | input | 44 | Four 11-bit symbol positions, slot 0 at the LSBs |
| pat_flat | input | 48 | Four 12-bit error patterns, slot 0 at the LSBs |
| mem_en | output | 1 | Buffer access strobe |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 12 | Byte address in the page buffer |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, one cycle after the read |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fail | output | 1 | The job had an uncorrectable pair |
| fail_why | output | 2 | Bit 0 out of range, bit 1 first-symbol overflow |
| corrected | output | 3 | Symbols corrected on success |

## Verification
The port-level signature of a wrong internal state depends on what is wrong. A mis-mapped position, a wrong nibble mask or a lost read-back value shows up as buffer bytes that differ from a bit-serial restatement of the packed layout. A wrong byte count or an extra state moves `done` by whole cycles, so the edge count checks catch it within the same job. A stale pair index or failure latch corrupts the `fail`/`fail_why`/`corrected` triple at that job's `done`. A `start` that is not ignored while busy shows up as extra buffer changes or a second `done`.

// File: rtl/symfix_pkg.sv
`timescale 1ns/1ps
package symfix_pkg;

  localparam int unsigned SYM_W       = 12;
  localparam int unsigned POS_W       = 11;
  localparam int unsigned DATA_BYTES  = 2048;
  localparam int unsigned SPARE_BYTES = 64;
  localparam int unsigned PAGE_BYTES  = DATA_BYTES + SPARE_BYTES;
  localparam int unsigned ADDR_W      = $clog2(PAGE_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = 11'd1374;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_READ, ST_WRITE, ST_DONE
  } fix_state_t;

  typedef struct packed {
    logic              ok;
    logic              bad_range;
    logic              bad_head;
    logic              two;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        m0;
    logic [7:0]        m1;
  } fix_plan_t;

  // Turns one (position, pattern) pair into the first byte address and the XOR masks
  function automatic fix_plan_t plan_fix(input logic [POS_W-1:0] p,
                                         input logic [SYM_W-1:0] s);
    fix_plan_t         r;
    logic [POS_W+1:0]  triple;
    logic [ADDR_W-1:0] half;
    r      = '0;
    triple = {2'b00, p} + {1'b0, p, 1'b0};
    half   = triple[ADDR_W:1];
    if (p > LAST_POS) begin
      r.bad_range = 1'b1;
    end else if (p == '0) begin
      if (s[11:8] != 4'h0) begin
        r.bad_head = 1'b1;
      end else begin
        r.ok = 1'b1;
        r.m0 = s[7:0];
      end
    end else if (p[0]) begin
      r.ok   = 1'b1;
      r.two  = 1'b1;
      r.addr = half;
      r.m0   = s[11:4];
      r.m1   = {s[3:0], 4'h0};
    end else begin
      r.ok   = 1'b1;
      r.two  = 1'b1;
      r.addr = half - ADDR_W'(1);
      r.m0   = {4'h0, s[11:8]};
      r.m1   = s[7:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/symfix_map.sv
`timescale 1ns/1ps
module symfix_map
  import symfix_pkg::*;
(
  input  logic [POS_W-1:0] pos,
  input  logic [SYM_W-1:0] pat,
  output fix_plan_t        plan
);
  always_comb plan = plan_fix(pos, pat);
endmodule

// File: rtl/symfix_seq.sv
`timescale 1ns/1ps
module symfix_seq
  import symfix_pkg::*;
#(
  parameter int unsigned MAX_ERR = 4,
  localparam int unsigned CNT_W = $clog2(MAX_ERR + 1),
  localparam int unsigned IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         cnt_in,
  input  logic [MAX_ERR*POS_W-1:0] pos_flat,
  input  logic [MAX_ERR*SYM_W-1:0] pat_flat,
  output logic [POS_W-1:0]         map_pos,
  output logic [SYM_W-1:0]         map_pat,
  input  fix_plan_t                map_plan,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     fail,
  output logic [1:0]               fail_why,
  output logic [CNT_W-1:0]         corrected
);

  fix_state_t       state;
  logic [CNT_W-1:0] n_q, idx_q;
  logic             second_q, bad_r_q, bad_h_q;
  fix_plan_t        plan_q;
  logic             fail_q;
  logic [1:0]       why_q;
  logic [CNT_W-1:0] corr_q;

  logic [POS_W-1:0] pos_q [MAX_ERR];
  logic [SYM_W-1:0] pat_q [MAX_ERR];

  // Named events for the assertions
  logic job_load, pair_take, pair_skip, byte_wr, job_end;
  assign job_load  = (state == ST_IDLE) && start;
  assign job_end   = (state == ST_PICK) && (idx_q == n_q);
  assign pair_take = (state == ST_PICK) && !job_end && map_plan.ok;
  assign pair_skip = (state == ST_PICK) && !job_end && !map_plan.ok;
  assign byte_wr   = (state == ST_WRITE);

  for (genvar k = 0; k < MAX_ERR; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_q[k] <= '0;
        pat_q[k] <= '0;
      end else if (job_load) begin
        pos_q[k] <= pos_flat[k*POS_W +: POS_W];
        pat_q[k] <= pat_flat[k*SYM_W +: SYM_W];
      end
    end
  end

  assign map_pos = pos_q[idx_q[IDX_W-1:0]];
  assign map_pat = pat_q[idx_q[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      n_q      <= '0;
      idx_q    <= '0;
      second_q <= 1'b0;
      bad_r_q  <= 1'b0;
      bad_h_q  <= 1'b0;
      plan_q   <= '0;
      fail_q   <= 1'b0;
      why_q    <= '0;
      corr_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          n_q     <= (cnt_in > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : cnt_in;
          idx_q   <= '0;
          bad_r_q <= 1'b0;
          bad_h_q <= 1'b0;
          fail_q  <= 1'b0;
          why_q   <= '0;
          corr_q  <= '0;
          state   <= ST_PICK;
        end
        ST_PICK: begin
          if (job_end) begin
            fail_q <= bad_r_q | bad_h_q;
            why_q  <= {bad_h_q, bad_r_q};
            corr_q <= (bad_r_q | bad_h_q) ? '0 : n_q;
            state  <= ST_DONE;
          end else if (map_plan.ok) begin
            plan_q   <= map_plan;
            second_q <= 1'b0;
            state    <= ST_READ;
          end else begin
            bad_r_q <= bad_r_q | map_plan.bad_range;
            bad_h_q <= bad_h_q | map_plan.bad_head;
            idx_q   <= idx_q + CNT_W'(1);
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          if (plan_q.two && !second_q) begin
            second_q <= 1'b1;
            state    <= ST_READ;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
            state <= ST_PICK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_en    = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = byte_wr;
  assign mem_addr  = plan_q.addr + {{(ADDR_W-1){1'b0}}, second_q};
  assign mem_wdata = mem_rdata ^ (second_q ? plan_q.m1 : plan_q.m0);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign fail      = fail_q;
  assign fail_why  = why_q;
  assign corrected = corr_q;

  // R7
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_en && !mem_we));
  // R7
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == $past(mem_addr)));
  // R4
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr < ADDR_W'(PAGE_BYTES)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  fail_zero_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (corrected == '0));
  // R10
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/symfix_corrector.sv
`timescale 1ns/1ps
module symfix_corrector
  import symfix_pkg::*;
#(
  parameter int unsigned MAX_ERR = 4,
  localparam int unsigned CNT_W = $clog2(MAX_ERR + 1)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         pair_count,
  input  logic [MAX_ERR*POS_W-1:0] pos_flat,
  input  logic [MAX_ERR*SYM_W-1:0] pat_flat,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     fail,
  output logic [1:0]               fail_why,
  output logic [CNT_W-1:0]         corrected
);

  logic [POS_W-1:0] map_pos;
  logic [SYM_W-1:0] map_pat;
  fix_plan_t        map_plan;

  symfix_map u_map (
    .pos  (map_pos),
    .pat  (map_pat),
    .plan (map_plan)
  );

  symfix_seq #(.MAX_ERR(MAX_ERR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cnt_in    (pair_count),
    .pos_flat  (pos_flat),
    .pat_flat  (pat_flat),
    .map_pos   (map_pos),
    .map_pat   (map_pat),
    .map_plan  (map_plan),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_why  (fail_why),
    .corrected (corrected)
  );

endmodule

// File: tb/test_symfix_corrector.sv
`timescale 1ns/1ps
module test_symfix_corrector;

  localparam int PAGE = 2112;

  typedef struct packed {
    logic [2:0]  cnt;
    logic [43:0] pos;
    logic [47:0] pat;
    logic        ef;
    logic [1:0]  ew;
    logic [2:0]  ec;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd1, {11'd0, 11'd0, 11'd0, 11'd5},       {12'h0, 12'h0, 12'h0, 12'hABC},       1'b0, 2'd0, 3'd1},
    '{3'd2, {11'd0, 11'd0, 11'd1, 11'd6},       {12'h0, 12'h0, 12'hFFF, 12'h123},     1'b0, 2'd0, 3'd2},
    '{3'd1, {11'd0, 11'd0, 11'd0, 11'd0},       {12'h0, 12'h0, 12'h0, 12'h0A5},       1'b0, 2'd0, 3'd1},
    '{3'd1, {11'd0, 11'd0, 11'd0, 11'd0},       {12'h0, 12'h0, 12'h0, 12'h1A5},       1'b1, 2'd2, 3'd0},
    '{3'd1, {11'd0, 11'd0, 11'd0, 11'd1365},    {12'h0, 12'h0, 12'h0, 12'h9E7},       1'b0, 2'd0, 3'd1},
    '{3'd2, {11'd0, 11'd0, 11'd1374, 11'd1366}, {12'h0, 12'h0, 12'hFED, 12'h456},     1'b0, 2'd0, 3'd2},
    '{3'd2, {11'd0, 11'd0, 11'd3, 11'd1375},    {12'h0, 12'h0, 12'h222, 12'h111},     1'b1, 2'd1, 3'd0},
    '{3'd4, {11'd1001, 11'd700, 11'd4, 11'd3},  {12'h001, 12'h800, 12'h3C3, 12'h5A5}, 1'b0, 2'd0, 3'd4},
    '{3'd0, {11'd0, 11'd0, 11'd0, 11'd9},       {12'h0, 12'h0, 12'h0, 12'h777},       1'b0, 2'd0, 3'd0},
    '{3'd7, {11'd13, 11'd12, 11'd11, 11'd10},   {12'h0F1, 12'h1E2, 12'h2D3, 12'h3C4}, 1'b0, 2'd0, 3'd4},
    '{3'd2, {11'd0, 11'd0, 11'd2000, 11'd0},    {12'h0, 12'h0, 12'h003, 12'hF00},     1'b1, 2'd3, 3'd0},
    '{3'd2, {11'd23, 11'd22, 11'd21, 11'd20},   {12'h444, 12'h333, 12'h222, 12'h111}, 1'b0, 2'd0, 3'd2}
  };
  localparam string TAGS [NV] = '{"R1", "R2", "R3", "R3", "R4", "R4",
                                  "R5", "R7", "R6", "R6", "R9", "R6"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  pair_count = '0;
  logic [43:0] pos_flat = '0;
  logic [47:0] pat_flat = '0;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done, fail;
  logic [1:0]  fail_why;
  logic [2:0]  corrected;

  int checks = 0;
  int fails  = 0;
  bit oob_seen = 1'b0;

  logic [7:0] pg [PAGE];
  logic [7:0] rf [PAGE];

  always #2 clk = ~clk;

  symfix_corrector i_symfix_corrector (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_count(pair_count),
    .pos_flat(pos_flat), .pat_flat(pat_flat),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_why(fail_why),
    .corrected(corrected)
  );

  // Page buffer model with one cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (int'(mem_addr) >= PAGE) oob_seen = 1'b1;
      else begin
        mem_rdata <= pg[mem_addr];
        if (mem_we) pg[mem_addr] <= mem_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Symbol p occupies stream bits 12p-4 .. 12p+7, MSB first in each byte
  function automatic bit pair_good(input int p, input int s);
    return (p <= 1374) && !(p == 0 && s > 255);
  endfunction

  function automatic int bytes_of(input int p, input int s);
    if (!pair_good(p, s)) return 0;
    return (p == 0) ? 1 : 2;
  endfunction

  task automatic ref_apply(input int p, input int s);
    if (!pair_good(p, s)) return;
    for (int i = 0; i < 12; i++) begin
      int b = 12 * p - 4 + i;
      if (b >= 0) rf[b / 8][7 - (b % 8)] ^= s[11 - i];
    end
  endtask

  task automatic mem_compare(input string req);
    int first = -1;
    for (int i = 0; i < PAGE; i++)
      if (first < 0 && pg[i] !== rf[i]) first = i;
    if (first >= 0)
      chk(1'b0, req, $sformatf("buffer byte %0d", first), int'(pg[first]), int'(rf[first]));
    else
      chk(!oob_seen, req, "buffer access out of range", int'(oob_seen), 0);
  endtask

  task automatic run_job(input vec_t v, input string tag);
    int n, want, e;
    n = (v.cnt > 3'd4) ? 4 : int'(v.cnt);
    want = 1;
    for (int k = 0; k < n; k++) begin
      int p = int'(v.pos[k*11 +: 11]);
      int s = int'(v.pat[k*12 +: 12]);
      want += 1 + 2 * bytes_of(p, s);
      ref_apply(p, s);
    end
    @(negedge clk);
    pair_count = v.cnt; pos_flat = v.pos; pat_flat = v.pat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 0;
    do begin
      @(posedge clk); e++;
      @(negedge clk);
    end while (!done && e < 2000);
    chk(e == want, "R8", {tag, " done edge count"}, e, want);
    chk({fail, fail_why, corrected} == {v.ef, v.ew, v.ec}, "R9",
        {tag, " result fail/why/corrected"}, int'({fail, fail_why, corrected}),
        int'({v.ef, v.ew, v.ec}));
    mem_compare(tag);
    @(negedge clk);
    chk(!done && !busy && {fail, fail_why, corrected} == {v.ef, v.ew, v.ec}, "R9",
        {tag, " result held after done"}, int'({done, busy}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGE; i++) begin
      pg[i] = 8'((i * 37 + 11) ^ (i >> 3));
      rf[i] = pg[i];
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({busy, done, fail, fail_why, corrected, mem_en} == '0, "R11",
        "outputs during reset", int'({busy, done, fail, fail_why, corrected, mem_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fail, fail_why, corrected, mem_en} == '0, "R11",
        "outputs after reset", int'({busy, done, fail, fail_why, corrected, mem_en}), 0);

    for (int vi = 0; vi < NV; vi++) run_job(VECS[vi], TAGS[vi]);

    // R10: a start pulse during a job is ignored
    begin
      int dones = 0;
      ref_apply(50, 12'h0F0);
      @(negedge clk);
      pair_count = 3'd1; pos_flat = {33'd0, 11'd50}; pat_flat = {36'd0, 12'h0F0}; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      pos_flat = {33'd0, 11'd51}; pat_flat = {36'd0, 12'hFFF}; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (done) dones++;
      end
      chk(dones == 1, "R10", "done pulses with start while busy", dones, 1);
      chk(!busy, "R10", "busy after ignored start", int'(busy), 0);
      mem_compare("R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule